// File: doc/BRIEF.md
# Flash Translation Layer Mapper

This block turns logical page reads and writes into commands for a flash array whose pages can be programmed only after their whole erase block is cleared. Data never overwrites a programmed page. Each write goes to the next erased page of an open block, and the page that held the old copy becomes stale. A table maps each logical page to its physical page, and a reverse table maps each physical page back to its logical page. A logical page that was never written reads back as all-ones, the erased value, and no flash access is made for it.

When erased pages run short, the block reclaims space before it serves a write. It picks a victim block, moves every still-valid page of that block to the open block, and erases the victim. It keeps an erase count per block and uses it as the tie-breaker, so that wear spreads across the blocks. The flash array sits outside the block behind a command port. A command is accepted when the flash is not busy. The flash marks the end of each command with a one-cycle done pulse, which carries the read data for a read.

Host requests use valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low during any operation, including reclamation. Read data comes back on valid/ready: `rsp_valid` and `rsp_data` hold until `rsp_ready` is high, and no new request is taken before then. Physical page address = block index × `PAGES_PER_BLOCK` + page index, and `PAGES_PER_BLOCK` is a power of two.

Top module: `ftl_mapper`

## Requirements
- R1: A read of a logical page that has never been written returns all-ones and issues no flash command.
- R2: A read returns the data of the most recent write to that logical page.
- R3: Programs go only to erased pages, and within the open block they go in ascending page order starting at page 0.
- R4: A write to a logical page that is already mapped programs a physical page different from the one that held the old copy, and that old page becomes stale.
- R5: When a write is accepted while fewer than `GC_MIN_FREE` erased pages remain, one reclamation runs before the write is programmed. The victim is the block with the most stale pages, with these rules in order: the open block is never chosen; a block with no stale pages is never chosen; a tie goes to the lowest erase count, then to the lowest index.
- R6: Reclamation reads every valid page of the victim and programs the same data elsewhere before it erases the victim, so no logical data is lost.
- R7: When the open block is full, the next block opened is the fully erased block with the lowest erase count, and a tie goes to the lowest index. Each erase adds one to that block's erase count, which saturates at its maximum.
- R8: Flash op codes are 1 = read, 2 = program and 3 = erase. An erase addresses page 0 of its block. A command stays asserted and unchanged while `fl_busy` is high, and at most one command is outstanding.
- R9: `req_ready` is low whenever `fl_busy` is high and for the whole time any operation is in progress.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lpn | input | LPN_W | Logical page number |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Host takes read data |
| rsp_data | output | DATA_W | Read data |
| fl_cmd_valid | output | 1 | Flash command valid |
| fl_cmd_op | output | 2 | Flash op code (1 = read, 2 = program, 3 = erase) |
| fl_cmd_addr | output | PPN_W | Physical page address |
| fl_cmd_wdata | output | DATA_W | Program data |
| fl_busy | input | 1 | Flash is executing a command |
| fl_done | input | 1 | One-cycle pulse when a command finishes |
| fl_rdata | input | DATA_W | Read data, valid while `fl_done` is high after a read |

## Verification
The assertions assume the following about the inputs:
- The flash raises `fl_done` only for the command it accepted, and keeps `fl_busy` high from acceptance until completion.
- The host holds `req_*` stable while it waits for ready.

The bench's flash model keeps to this contract, with a read latency of 3 cycles, a program latency of 5 and an erase latency of 40. Its host driver drives on falling edges and changes a request only after the request has been taken. The logical page space is kept at no more than the physical capacity less two blocks, which guarantees that a victim and an erased destination always exist. Stimulus mixes random writes, many aimed at a small set of hot pages, with random reads and random response back-pressure.

// File: rtl/ftl_pkg.sv
package ftl_pkg;
  typedef enum logic [1:0] {
    FOP_NONE  = 2'd0,
    FOP_READ  = 2'd1,
    FOP_PROG  = 2'd2,
    FOP_ERASE = 2'd3
  } fop_e;

  typedef enum logic [1:0] {
    PG_FREE  = 2'd0,
    PG_VALID = 2'd1,
    PG_STALE = 2'd2
  } pstate_e;
endpackage

// File: rtl/ftl_victim_pick.sv
module ftl_victim_pick #(
  parameter int NB     = 4,
  parameter int CNT_W  = 6,
  parameter int ECNT_W = 17,
  parameter int BLK_W  = 2
) (
  input  logic [CNT_W-1:0]  stale_i [NB],
  input  logic [ECNT_W-1:0] ecnt_i  [NB],
  input  logic [BLK_W-1:0]  open_blk_i,
  output logic              found_o,
  output logic [BLK_W-1:0]  blk_o
);
  logic [CNT_W-1:0]  best_stale;
  logic [ECNT_W-1:0] best_ecnt;

  always_comb begin
    found_o    = 1'b0;
    blk_o      = '0;
    best_stale = '0;
    best_ecnt  = '0;
    for (int b = 0; b < NB; b++) begin
      if (stale_i[b] != '0 && BLK_W'(b) != open_blk_i) begin
        if (!found_o || stale_i[b] > best_stale ||
            (stale_i[b] == best_stale && ecnt_i[b] < best_ecnt)) begin
          found_o    = 1'b1;
          blk_o      = BLK_W'(b);
          best_stale = stale_i[b];
          best_ecnt  = ecnt_i[b];
        end
      end
    end
  end
endmodule

// File: rtl/ftl_free_pick.sv
module ftl_free_pick #(
  parameter int NB     = 4,
  parameter int CNT_W  = 6,
  parameter int ECNT_W = 17,
  parameter int BLK_W  = 2
) (
  input  logic [CNT_W-1:0]  fill_i [NB],
  input  logic [ECNT_W-1:0] ecnt_i [NB],
  output logic              found_o,
  output logic [BLK_W-1:0]  blk_o
);
  logic [ECNT_W-1:0] best_ecnt;

  always_comb begin
    found_o   = 1'b0;
    blk_o     = '0;
    best_ecnt = '0;
    for (int b = 0; b < NB; b++) begin
      if (fill_i[b] == '0 && (!found_o || ecnt_i[b] < best_ecnt)) begin
        found_o   = 1'b1;
        blk_o     = BLK_W'(b);
        best_ecnt = ecnt_i[b];
      end
    end
  end
endmodule

// File: rtl/ftl_mapper.sv
module ftl_mapper
  import ftl_pkg::*;
#(
  parameter int NUM_BLOCKS      = 4,
  parameter int PAGES_PER_BLOCK = 32,
  parameter int LOGICAL_PAGES   = 64,
  parameter int DATA_W          = 16,
  parameter int GC_MIN_FREE     = 32,
  parameter int ERASE_CNT_W     = 17,
  localparam int PHYS_PAGES = NUM_BLOCKS * PAGES_PER_BLOCK,
  localparam int PPN_W      = $clog2(PHYS_PAGES),
  localparam int LPN_W      = $clog2(LOGICAL_PAGES),
  localparam int BLK_W      = $clog2(NUM_BLOCKS),
  localparam int PG_W       = $clog2(PAGES_PER_BLOCK),
  localparam int CNT_W      = PG_W + 1,
  localparam int FREE_W     = $clog2(PHYS_PAGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [LPN_W-1:0]  req_lpn,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              fl_cmd_valid,
  output logic [1:0]        fl_cmd_op,
  output logic [PPN_W-1:0]  fl_cmd_addr,
  output logic [DATA_W-1:0] fl_cmd_wdata,
  input  logic              fl_busy,
  input  logic              fl_done,
  input  logic [DATA_W-1:0] fl_rdata
);
  typedef enum logic [3:0] {
    S_IDLE, S_RD_ISSUE, S_RD_WAIT, S_RESP,
    S_WR_CHECK, S_WR_ISSUE, S_WR_WAIT,
    S_GC_SCAN, S_GC_RD, S_GC_RDW, S_GC_PG, S_GC_PGW, S_GC_ER, S_GC_ERW
  } st_e;

  st_e state;

  // Mapping state
  logic              map_vld [LOGICAL_PAGES];
  logic [PPN_W-1:0]  map_ppn [LOGICAL_PAGES];
  logic [LPN_W-1:0]  rev_lpn [PHYS_PAGES];
  pstate_e           pst     [PHYS_PAGES];
  logic [CNT_W-1:0]  fill_q  [NUM_BLOCKS];
  logic [CNT_W-1:0]  stale_q [NUM_BLOCKS];
  logic [ERASE_CNT_W-1:0] ecnt_q [NUM_BLOCKS];
  logic [FREE_W-1:0] free_cnt;
  logic [BLK_W-1:0]  active_q;

  // Operation context
  logic [LPN_W-1:0]  lpn_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] data_q;
  logic [BLK_W-1:0]  victim_q;
  logic [PG_W-1:0]   scan_q;
  logic              gc_done_q;

  logic              vic_found, fb_found;
  logic [BLK_W-1:0]  vic_blk, fb_blk;
  logic              act_full, cmd_take, scan_last;
  logic [PPN_W-1:0]  prog_addr, src_addr, old_ppn;

  assign act_full  = (fill_q[active_q] == CNT_W'(PAGES_PER_BLOCK));
  assign prog_addr = {active_q, fill_q[active_q][PG_W-1:0]};
  assign src_addr  = {victim_q, scan_q};
  assign old_ppn   = map_ppn[lpn_q];
  assign scan_last = (scan_q == PG_W'(PAGES_PER_BLOCK - 1));
  assign cmd_take  = fl_cmd_valid && !fl_busy;

  ftl_victim_pick #(
    .NB(NUM_BLOCKS), .CNT_W(CNT_W), .ECNT_W(ERASE_CNT_W), .BLK_W(BLK_W)
  ) u_victim (
    .stale_i(stale_q), .ecnt_i(ecnt_q), .open_blk_i(active_q),
    .found_o(vic_found), .blk_o(vic_blk)
  );

  ftl_free_pick #(
    .NB(NUM_BLOCKS), .CNT_W(CNT_W), .ECNT_W(ERASE_CNT_W), .BLK_W(BLK_W)
  ) u_free (
    .fill_i(fill_q), .ecnt_i(ecnt_q), .found_o(fb_found), .blk_o(fb_blk)
  );

  assign req_ready = (state == S_IDLE) && !fl_busy;
  assign rsp_valid = (state == S_RESP);
  assign rsp_data  = data_q;

  always_comb begin
    fl_cmd_valid = 1'b0;
    fl_cmd_op    = FOP_NONE;
    fl_cmd_addr  = prog_addr;
    fl_cmd_wdata = wdata_q;
    case (state)
      S_RD_ISSUE: begin
        fl_cmd_valid = 1'b1;
        fl_cmd_op    = FOP_READ;
        fl_cmd_addr  = old_ppn;
      end
      S_WR_ISSUE: begin
        fl_cmd_valid = !act_full;
        fl_cmd_op    = FOP_PROG;
      end
      S_GC_RD: begin
        fl_cmd_valid = 1'b1;
        fl_cmd_op    = FOP_READ;
        fl_cmd_addr  = src_addr;
      end
      S_GC_PG: begin
        fl_cmd_valid = !act_full;
        fl_cmd_op    = FOP_PROG;
        fl_cmd_wdata = data_q;
      end
      S_GC_ER: begin
        fl_cmd_valid = 1'b1;
        fl_cmd_op    = FOP_ERASE;
        fl_cmd_addr  = {victim_q, {PG_W{1'b0}}};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      active_q  <= '0;
      free_cnt  <= FREE_W'(PHYS_PAGES);
      lpn_q     <= '0;
      wdata_q   <= '0;
      data_q    <= '0;
      victim_q  <= '0;
      scan_q    <= '0;
      gc_done_q <= 1'b0;
      for (int i = 0; i < LOGICAL_PAGES; i++) begin
        map_vld[i] <= 1'b0;
        map_ppn[i] <= '0;
      end
      for (int i = 0; i < PHYS_PAGES; i++) begin
        pst[i]     <= PG_FREE;
        rev_lpn[i] <= '0;
      end
      for (int b = 0; b < NUM_BLOCKS; b++) begin
        fill_q[b]  <= '0;
        stale_q[b] <= '0;
        ecnt_q[b]  <= '0;
      end
    end else begin
      case (state)
        S_IDLE: if (req_valid && req_ready) begin
          lpn_q <= req_lpn;
          if (req_write) begin
            wdata_q   <= req_wdata;
            gc_done_q <= 1'b0;
            state     <= S_WR_CHECK;
          end else if (map_vld[req_lpn]) begin
            state <= S_RD_ISSUE;
          end else begin
            data_q <= '1;
            state  <= S_RESP;
          end
        end
        S_RD_ISSUE: if (cmd_take) state <= S_RD_WAIT;
        S_RD_WAIT: if (fl_done) begin
          data_q <= fl_rdata;
          state  <= S_RESP;
        end
        S_RESP: if (rsp_ready) state <= S_IDLE;
        S_WR_CHECK: begin
          if (!gc_done_q && free_cnt < FREE_W'(GC_MIN_FREE) && vic_found) begin
            victim_q  <= vic_blk;
            scan_q    <= '0;
            gc_done_q <= 1'b1;
            state     <= S_GC_SCAN;
          end else begin
            state <= S_WR_ISSUE;
          end
        end
        S_WR_ISSUE: begin
          if (act_full) begin
            if (fb_found) active_q <= fb_blk;
          end else if (cmd_take) begin
            state <= S_WR_WAIT;
          end
        end
        S_WR_WAIT: if (fl_done) begin
          if (map_vld[lpn_q]) begin
            pst[old_ppn] <= PG_STALE;
            stale_q[old_ppn[PPN_W-1:PG_W]] <= stale_q[old_ppn[PPN_W-1:PG_W]] + 1'b1;
          end
          pst[prog_addr]     <= PG_VALID;
          rev_lpn[prog_addr] <= lpn_q;
          map_vld[lpn_q]     <= 1'b1;
          map_ppn[lpn_q]     <= prog_addr;
          fill_q[active_q]   <= fill_q[active_q] + 1'b1;
          free_cnt           <= free_cnt - 1'b1;
          state              <= S_IDLE;
        end
        S_GC_SCAN: begin
          if (pst[src_addr] == PG_VALID) state <= S_GC_RD;
          else if (scan_last)            state <= S_GC_ER;
          else                           scan_q <= scan_q + 1'b1;
        end
        S_GC_RD: if (cmd_take) state <= S_GC_RDW;
        S_GC_RDW: if (fl_done) begin
          data_q <= fl_rdata;
          state  <= S_GC_PG;
        end
        S_GC_PG: begin
          if (act_full) begin
            if (fb_found) active_q <= fb_blk;
          end else if (cmd_take) begin
            state <= S_GC_PGW;
          end
        end
        S_GC_PGW: if (fl_done) begin
          map_ppn[rev_lpn[src_addr]] <= prog_addr;
          rev_lpn[prog_addr]         <= rev_lpn[src_addr];
          pst[src_addr]              <= PG_STALE;
          pst[prog_addr]             <= PG_VALID;
          stale_q[victim_q]          <= stale_q[victim_q] + 1'b1;
          fill_q[active_q]           <= fill_q[active_q] + 1'b1;
          free_cnt                   <= free_cnt - 1'b1;
          if (scan_last) begin
            state <= S_GC_ER;
          end else begin
            scan_q <= scan_q + 1'b1;
            state  <= S_GC_SCAN;
          end
        end
        S_GC_ER: if (cmd_take) state <= S_GC_ERW;
        S_GC_ERW: if (fl_done) begin
          for (int p = 0; p < PAGES_PER_BLOCK; p++) begin
            pst[{victim_q, PG_W'(p)}] <= PG_FREE;
          end
          fill_q[victim_q]  <= '0;
          stale_q[victim_q] <= '0;
          if (ecnt_q[victim_q] != '1) ecnt_q[victim_q] <= ecnt_q[victim_q] + 1'b1;
          free_cnt <= free_cnt + FREE_W'(PAGES_PER_BLOCK);
          state    <= S_WR_CHECK;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cmd_valid && fl_busy |=> fl_cmd_valid && $stable(fl_cmd_addr) && $stable(fl_cmd_op)); // R8
  AST_PROG_ERASED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cmd_valid && fl_cmd_op == FOP_PROG |-> pst[fl_cmd_addr] == PG_FREE); // R3
  AST_STALL_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fl_busy |-> !req_ready); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fl_done && state == S_WR_WAIT |-> free_cnt != '0); // R3
endmodule

// File: tb/ftl_mapper_tb.sv
module ftl_mapper_tb;
  localparam int NB = 4, PPB = 32, LOGP = 64, DW = 16, GCMIN = 32;
  localparam int PHYS = NB * PPB;
  localparam int RD_LAT = 3, PG_LAT = 5, ER_LAT = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [5:0]    req_lpn = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, fl_cmd_valid;
  logic [DW-1:0] rsp_data, fl_cmd_wdata;
  logic [1:0]    fl_cmd_op;
  logic [6:0]    fl_cmd_addr;
  logic          fl_busy = 1'b0, fl_done = 1'b0;
  logic [DW-1:0] fl_rdata = '0;

  ftl_mapper #(.NUM_BLOCKS(NB), .PAGES_PER_BLOCK(PPB), .LOGICAL_PAGES(LOGP),
               .DATA_W(DW), .GC_MIN_FREE(GCMIN), .ERASE_CNT_W(17)) u_dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_lpn, .req_wdata,
    .rsp_valid, .rsp_ready, .rsp_data, .fl_cmd_valid, .fl_cmd_op, .fl_cmd_addr,
    .fl_cmd_wdata, .fl_busy, .fl_done, .fl_rdata);

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference model of flash contents and mapping, fed by observed traffic
  logic [DW-1:0] fdata [PHYS];
  bit   fprog [PHYS];
  int   b_map [LOGP];
  int   b_rev [PHYS];
  int   b_st [PHYS];
  int   b_fill [NB], b_stale [NB], b_ecnt [NB];
  int   b_active = 0, b_free = PHYS, last_rd = 0, exp_vic = -1, n_accept = 0;
  bit   rd_pending = 0, host_wr = 0;
  int   host_lpn = 0;
  logic [DW-1:0] exp_data [LOGP];
  int   cnt = 0;
  logic [1:0] pend_op = '0;
  int   pend_addr = 0;

  function automatic int ref_victim();
    int best = -1;
    for (int b = 0; b < NB; b++)
      if (b_stale[b] > 0 && b != b_active)
        if (best < 0 || b_stale[b] > b_stale[best] ||
            (b_stale[b] == b_stale[best] && b_ecnt[b] < b_ecnt[best])) best = b;
    return best;
  endfunction

  function automatic int ref_freeblk();
    int best = -1;
    for (int b = 0; b < NB; b++)
      if (b_fill[b] == 0 && (best < 0 || b_ecnt[b] < b_ecnt[best])) best = b;
    return best;
  endfunction

  // Flash model: accepts when idle, busy for a latency, done pulse at the end
  always @(posedge clk) begin
    if (!rst_n) begin
      fl_busy <= 1'b0;
      fl_done <= 1'b0;
    end else begin
      fl_done <= 1'b0;
      if (fl_busy) begin
        if (cnt == 1) begin
          fl_busy <= 1'b0;
          fl_done <= 1'b1;
          if (pend_op == 2'd1) fl_rdata <= fdata[pend_addr];
        end
        cnt <= cnt - 1;
      end else if (fl_cmd_valid) begin
        automatic int a = int'(fl_cmd_addr);
        automatic int blk = a / PPB;
        n_accept++;
        pend_op   <= fl_cmd_op;
        pend_addr <= a;
        fl_busy   <= 1'b1;
        chk(fl_cmd_op != 2'd0, "R8", "flash op code", fl_cmd_op, 1);
        if (fl_cmd_op == 2'd1) begin
          cnt <= RD_LAT;
          if (host_wr) rd_pending = 1;
          last_rd = a;
        end else if (fl_cmd_op == 2'd2) begin
          automatic int lpn;
          cnt <= PG_LAT;
          chk(!fprog[a], "R3", "program to unerased page", a, -1);
          if (blk != b_active) begin
            chk(blk == ref_freeblk(), "R7", "new open block", blk, ref_freeblk());
            b_active = blk;
          end
          chk(a % PPB == b_fill[blk], "R3", "page order in open block", a % PPB, b_fill[blk]);
          if (rd_pending) begin
            lpn = b_rev[last_rd];
            chk(fl_cmd_wdata == fdata[last_rd], "R6", "copied data", fl_cmd_wdata, fdata[last_rd]);
            b_st[last_rd] = 2;
            b_stale[last_rd / PPB]++;
            rd_pending = 0;
          end else begin
            lpn = host_lpn;
            if (b_map[lpn] >= 0) begin
              chk(a != b_map[lpn], "R4", "rewrite lands on new page", a, -1);
              b_st[b_map[lpn]] = 2;
              b_stale[b_map[lpn] / PPB]++;
            end
          end
          b_map[lpn] = a;
          b_rev[a] = lpn;
          b_st[a] = 1;
          fprog[a] = 1;
          fdata[a] = fl_cmd_wdata;
          b_fill[blk]++;
          b_free--;
        end else if (fl_cmd_op == 2'd3) begin
          automatic int nvalid = 0;
          cnt <= ER_LAT;
          chk(a % PPB == 0, "R8", "erase address aligned", a % PPB, 0);
          chk(blk == exp_vic, "R5", "victim block", blk, exp_vic);
          for (int p = 0; p < PPB; p++) if (b_st[blk*PPB+p] == 1) nvalid++;
          chk(nvalid == 0, "R6", "valid pages left in erased block", nvalid, 0);
          for (int p = 0; p < PPB; p++) begin
            b_st[blk*PPB+p] = 0;
            fprog[blk*PPB+p] = 0;
            fdata[blk*PPB+p] = '1;
          end
          b_fill[blk] = 0;
          b_stale[blk] = 0;
          b_ecnt[blk]++;
          b_free += PPB;
          exp_vic = -1;
        end
      end
    end
  end

  // Stall check at the falling edge
  always @(negedge clk)
    if (rst_n && fl_busy) chk(!req_ready, "R9", "ready while flash busy", req_ready, 0);

  task automatic do_write(input int lpn, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_lpn = 6'(lpn); req_wdata = d;
    while (!req_ready) @(negedge clk);
    host_wr = 1; host_lpn = lpn;
    exp_vic = (b_free < GCMIN) ? ref_victim() : -1;
    exp_data[lpn] = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9", "ready during write", req_ready, 0);
    while (!req_ready) @(negedge clk);
    chk(exp_vic == -1, "R5", "expected reclamation not done", exp_vic, -1);
    host_wr = 0;
  endtask

  task automatic do_read(input int lpn, input int hold, input string req);
    int acc0;
    logic [DW-1:0] first;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_lpn = 6'(lpn);
    while (!req_ready) @(negedge clk);
    acc0 = n_accept;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    first = rsp_data;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == first, "R10", "response held", rsp_data, first);
    end
    chk(rsp_data == exp_data[lpn], req, "read data", rsp_data, exp_data[lpn]);
    if (b_map[lpn] < 0)
      chk(n_accept == acc0, "R1", "flash commands for unwritten read", n_accept - acc0, 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!finished && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      failures++;
      $display("FAIL R9 watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < PHYS; i++) begin
      fdata[i] = '1; fprog[i] = 0; b_rev[i] = 0; b_st[i] = 0;
    end
    for (int i = 0; i < LOGP; i++) begin
      b_map[i] = -1; exp_data[i] = '1;
    end
    for (int b = 0; b < NB; b++) begin
      b_fill[b] = 0; b_stale[b] = 0; b_ecnt[b] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "reset ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R10", "reset rsp_valid", rsp_valid, 0);
    chk(fl_cmd_valid == 1'b0, "R8", "reset cmd_valid", fl_cmd_valid, 0);

    do_read(5, 2, "R1");
    do_write(3, 16'h1234);
    do_read(3, 0, "R2");
    for (int k = 0; k < 5; k++) do_write(3, 16'(16'h2000 + k));
    do_read(3, 3, "R4");
    do_read(63, 1, "R1");
    // Fill the logical space, then hammer a hot page to force reclamation
    for (int l = 0; l < LOGP; l++) do_write(l, 16'(16'h4000 + l));
    for (int k = 0; k < 100; k++) do_write(7, 16'(16'h5000 + k));
    for (int l = 0; l < LOGP; l += 9) do_read(l, 0, "R6");

    for (int i = 0; i < 1500; i++) begin
      int r = int'($urandom % 100);
      int lpn = ($urandom % 2 == 0) ? int'($urandom % 8) : int'($urandom % LOGP);
      if (r < 65) do_write(lpn, 16'($urandom));
      else        do_read(lpn, int'($urandom % 3), "R2");
    end
    for (int l = 0; l < LOGP; l++) do_read(l, 0, "R6");
    chk(b_ecnt[0] + b_ecnt[1] + b_ecnt[2] + b_ecnt[3] > 0, "R7", "erases observed", b_ecnt[0], 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule